// File: doc/BRIEF.md
# Corrected error record counter

This block keeps one error record for a RAM-protection subsystem. Error reports come in as a single-cycle strobe. Each report carries a syndrome, a flag that says whether the error was corrected, and 32 bits of location information. The first report into an empty record captures the syndrome and the location word and marks the record valid. After that, every corrected error whose syndrome differs from the captured one advances an 8-bit counter. When the counter wraps, a sticky overflow flag is set, and that flag drives a fault interrupt while the interrupt enable is high.

Software sees the record as one 64-bit word and writes it through a simple write port. `reg_sel_i` picks the target: 0 selects the record word, 1 selects the status clear. The 32-bit information field can only be written while the record is not valid. The counter can be written at any time. The two flags clear when 0 is written to them. A corrected error that is lost because a counter write happens in the same cycle sets a rounding-error flag.

Top module: `err_rec_misc`

## Requirements
- R1: After reset, `misc_rdata_o` is all zero, `rec_valid_o` is 0, `rec_syn_o` is 0 and `fault_irq_o` is 0.
- R2: An error strobe while `rec_valid_o` is 0 loads the syndrome into `rec_syn_o` and the location word into bits [31:0], and sets `rec_valid_o` on the next cycle. The corrected flag does not matter for this load, and the count is not changed.
- R3: A corrected error whose syndrome differs from `rec_syn_o` while the record is valid increments the count in bits [39:32] by one on the next cycle.
- R4: While the record is valid, the count, the information field and `rec_syn_o` stay the same in two cases: a corrected error with the recorded syndrome, and an uncorrected error with any syndrome.
- R5: An increment from count 0xFF gives 0x00 and sets the overflow bit [40]. That bit stays 1 through further increments until it is cleared.
- R6: `fault_irq_o` is 1 exactly in the cycles where the overflow bit is 1 and `irq_en_i` was 1 on the clock edge that produced that cycle.
- R7: A record write (`reg_sel_i`=0) loads the count from data bits [39:32]. A 0 in data bit [40] or bit [41] clears the overflow or rounding-error flag. A 1 in either bit leaves that flag unchanged.
- R8: A record write changes bits [31:0] only when `rec_valid_o` is 0. While it is 1, the information field keeps its value.
- R9: Bits [63:42] always read 0, and so do information bits [31:INFO_W] (INFO_W defaults to 25). Writing ones to these bits has no effect.
- R10: A counter write in the same cycle as an increment-qualifying error stores the written count and sets the rounding-error bit [41], even if data bit [41] is 0.
- R11: A status write (`reg_sel_i`=1) with data bit [0] = 1 clears `rec_valid_o`. With data bit [0] = 0 it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_valid_i | input | 1 | Error report strobe |
| err_corr_i | input | 1 | 1 when the reported error was corrected |
| err_syn_i | input | SYN_W | Syndrome of the reported error |
| err_info_i | input | 32 | Location information of the reported error |
| reg_wr_i | input | 1 | Software write strobe |
| reg_sel_i | input | 1 | Write target: 0 = record word, 1 = status clear |
| reg_wdata_i | input | 64 | Software write data |
| irq_en_i | input | 1 | Enable for the corrected-fault interrupt |
| misc_rdata_o | output | 64 | Record read value: info, count, overflow, rounding-error |
| rec_valid_o | output | 1 | Record-valid status |
| rec_syn_o | output | SYN_W | Recorded syndrome |
| fault_irq_o | output | 1 | Fault-handling interrupt |

## Verification
The assertions check the following on every cycle:
- a single-step count after each qualifying error;
- the overflow flag staying set unless a write clears it;
- the rounding-error flag after a write/increment collision;
- the information field and syndrome staying frozen while the record is valid;
- the interrupt never being high without the overflow bit.

Some behaviours need the bench's scenarios:
- the exact wrap from 0xFF to 0x00;
- the masking of the upper information bits and the reserved bits;
- the rejection of matching-syndrome and uncorrected errors;
- reopening a cleared record for a new capture.

The bench checks these against a model that it keeps of its own.

// File: rtl/err_rec_pkg.sv
`timescale 1ns/1ps
package err_rec_pkg;
  localparam int REC_W    = 64;
  localparam int INFO_FW  = 32;
  localparam int CNT_LSB  = 32;
  localparam int CNT_W    = 8;
  localparam int OVF_BIT  = 40;
  localparam int RE_BIT   = 41;

  function automatic logic [REC_W-1:0] pack_rec(input logic [CNT_W-1:0] cnt,
                                                input logic ovf, input logic re,
                                                input logic [INFO_FW-1:0] info);
    logic [REC_W-1:0] r;
    r = '0;
    r[INFO_FW-1:0]             = info;
    r[CNT_LSB+CNT_W-1:CNT_LSB] = cnt;
    r[OVF_BIT]                 = ovf;
    r[RE_BIT]                  = re;
    return r;
  endfunction
endpackage

// File: rtl/err_rec_counter.sv
`timescale 1ns/1ps
module err_rec_counter #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          wr_i,
  input  logic [CW-1:0] wr_cnt_i,
  input  logic          wr_ovf_i,
  input  logic          wr_re_i,
  output logic [CW-1:0] cnt_o,
  output logic          ovf_o,
  output logic          ovf_d_o,
  output logic          re_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d, re_q, re_d;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    re_d  = re_q;
    if (wr_i) begin
      cnt_d = wr_cnt_i;
      if (!wr_ovf_i) ovf_d = 1'b0;
      // lost increment beats a clear
      if (inc_i)          re_d = 1'b1;
      else if (!wr_re_i)  re_d = 1'b0;
    end else if (inc_i) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_MAX) ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      re_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      re_q  <= re_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign ovf_o   = ovf_q;
  assign ovf_d_o = ovf_d;
  assign re_o    = re_q;

  assert_cnt_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_ovf_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !(wr_i && !wr_ovf_i)) |=> ovf_q);
  assert_re_collision_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && wr_i) |=> (re_q && cnt_q == $past(wr_cnt_i)));
endmodule

// File: rtl/err_rec_capture.sv
`timescale 1ns/1ps
module err_rec_capture #(
  parameter int SYN_W  = 8,
  parameter int INFO_W = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_valid_i,
  input  logic              err_corr_i,
  input  logic [SYN_W-1:0]  err_syn_i,
  input  logic [INFO_W-1:0] err_info_i,
  input  logic              wr_info_i,
  input  logic [INFO_W-1:0] wr_info_data_i,
  input  logic              clr_valid_i,
  output logic              valid_o,
  output logic [SYN_W-1:0]  syn_o,
  output logic [INFO_W-1:0] info_o,
  output logic              inc_o
);
  logic              valid_q, valid_d, load;
  logic [SYN_W-1:0]  syn_q, syn_d;
  logic [INFO_W-1:0] info_q, info_d;

  assign load  = err_valid_i && !valid_q;
  assign inc_o = err_valid_i && valid_q && err_corr_i && (err_syn_i != syn_q);

  always_comb begin
    valid_d = valid_q;
    syn_d   = syn_q;
    info_d  = info_q;
    if (load) begin
      valid_d = 1'b1;
      syn_d   = err_syn_i;
      info_d  = err_info_i;
    end else begin
      if (clr_valid_i)             valid_d = 1'b0;
      if (wr_info_i && !valid_q)   info_d  = wr_info_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      syn_q   <= '0;
      info_q  <= '0;
    end else begin
      valid_q <= valid_d;
      syn_q   <= syn_d;
      info_q  <= info_d;
    end
  end

  assign valid_o = valid_q;
  assign syn_o   = syn_q;
  assign info_o  = info_q;

  assert_info_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> $stable(info_q));
  assert_syn_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> $stable(syn_q));
  assert_load_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_valid_i && !valid_q) |=> (valid_q && syn_q == $past(err_syn_i)));
endmodule

// File: rtl/err_rec_irq.sv
`timescale 1ns/1ps
module err_rec_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ovf_d_i,
  input  logic ovf_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= en_i && ovf_d_i;
  end

  assign irq_o = irq_q;

  assert_irq_needs_ovf_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> ovf_i);
endmodule

// File: rtl/err_rec_misc.sv
`timescale 1ns/1ps
module err_rec_misc
  import err_rec_pkg::*;
#(
  parameter int SYN_W  = 8,
  parameter int INFO_W = 25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             err_valid_i,
  input  logic             err_corr_i,
  input  logic [SYN_W-1:0] err_syn_i,
  input  logic [31:0]      err_info_i,
  input  logic             reg_wr_i,
  input  logic             reg_sel_i,
  input  logic [63:0]      reg_wdata_i,
  input  logic             irq_en_i,
  output logic [63:0]      misc_rdata_o,
  output logic             rec_valid_o,
  output logic [SYN_W-1:0] rec_syn_o,
  output logic             fault_irq_o
);
  localparam int CNT_MSB = CNT_LSB + CNT_W - 1;

  logic              wr_rec, wr_stat, inc;
  logic [CNT_W-1:0]  cnt;
  logic              ovf, ovf_d, re;
  logic [INFO_W-1:0] info;
  logic [INFO_FW-1:0] info_ext;

  assign wr_rec  = reg_wr_i && !reg_sel_i;
  assign wr_stat = reg_wr_i &&  reg_sel_i;

  err_rec_capture #(.SYN_W(SYN_W), .INFO_W(INFO_W)) u_capture (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .err_valid_i    (err_valid_i),
    .err_corr_i     (err_corr_i),
    .err_syn_i      (err_syn_i),
    .err_info_i     (err_info_i[INFO_W-1:0]),
    .wr_info_i      (wr_rec),
    .wr_info_data_i (reg_wdata_i[INFO_W-1:0]),
    .clr_valid_i    (wr_stat && reg_wdata_i[0]),
    .valid_o        (rec_valid_o),
    .syn_o          (rec_syn_o),
    .info_o         (info),
    .inc_o          (inc)
  );

  err_rec_counter #(.CW(CNT_W)) u_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (inc),
    .wr_i     (wr_rec),
    .wr_cnt_i (reg_wdata_i[CNT_MSB:CNT_LSB]),
    .wr_ovf_i (reg_wdata_i[OVF_BIT]),
    .wr_re_i  (reg_wdata_i[RE_BIT]),
    .cnt_o    (cnt),
    .ovf_o    (ovf),
    .ovf_d_o  (ovf_d),
    .re_o     (re)
  );

  err_rec_irq u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (irq_en_i),
    .ovf_d_i (ovf_d),
    .ovf_i   (ovf),
    .irq_o   (fault_irq_o)
  );

  generate
    if (INFO_W < INFO_FW) begin : g_info_pad
      assign info_ext = {{(INFO_FW-INFO_W){1'b0}}, info};
      logic unused_hi;
      assign unused_hi = ^{err_info_i[INFO_FW-1:INFO_W], reg_wdata_i[INFO_FW-1:INFO_W],
                           reg_wdata_i[63:RE_BIT+1]};
    end else begin : g_info_full
      assign info_ext = info;
      logic unused_hi;
      assign unused_hi = ^reg_wdata_i[63:RE_BIT+1];
    end
  endgenerate

  assign misc_rdata_o = pack_rec(cnt, ovf, re, info_ext);
endmodule

// File: tb/err_rec_misc_tb.sv
`timescale 1ns/1ps
module err_rec_misc_tb;
  localparam int SYN_W  = 8;
  localparam int INFO_W = 25;
  localparam logic [31:0] IMASK = (32'h1 << INFO_W) - 1;

  logic clk_i = 0, rst_ni = 0;
  logic err_valid_i = 0, err_corr_i = 0, reg_wr_i = 0, reg_sel_i = 0, irq_en_i = 0;
  logic [SYN_W-1:0] err_syn_i = '0;
  logic [31:0] err_info_i = '0;
  logic [63:0] reg_wdata_i = '0;
  logic [63:0] misc_rdata_o;
  logic rec_valid_o, fault_irq_o;
  logic [SYN_W-1:0] rec_syn_o;

  always #2 clk_i = ~clk_i;

  err_rec_misc #(.SYN_W(SYN_W), .INFO_W(INFO_W)) u_dut (.*);

  int checks = 0, fails = 0;
  logic [73:0] exp_q[$];
  string tag_q[$];

  // reference model state
  logic [7:0] m_cnt = 0; logic m_ovf = 0, m_re = 0, m_valid = 0, m_irq = 0;
  logic [31:0] m_info = 0; logic [SYN_W-1:0] m_syn = 0;

  function automatic logic [63:0] rec();
    return {22'd0, m_re, m_ovf, m_cnt, m_info};
  endfunction

  task automatic step(input logic ev, input logic corr, input logic [SYN_W-1:0] syn,
                      input logic [31:0] info, input logic wr, input logic sel,
                      input logic [63:0] wd, input logic en, input string tag);
    logic load, inc, wrec, wst;
    @(negedge clk_i);
    err_valid_i = ev; err_corr_i = corr; err_syn_i = syn; err_info_i = info;
    reg_wr_i = wr; reg_sel_i = sel; reg_wdata_i = wd; irq_en_i = en;
    load = ev && !m_valid;
    inc  = ev && m_valid && corr && (syn != m_syn);
    wrec = wr && !sel; wst = wr && sel;
    if (wrec) begin
      m_cnt = wd[39:32];
      if (!wd[40]) m_ovf = 0;
      if (inc) m_re = 1; else if (!wd[41]) m_re = 0;
    end else if (inc) begin
      if (m_cnt == 8'hFF) m_ovf = 1;
      m_cnt = m_cnt + 1;
    end
    if (load) begin m_info = info & IMASK; m_syn = syn; end
    else if (wrec && !m_valid) m_info = wd[31:0] & IMASK;
    if (load) m_valid = 1; else if (wst && wd[0]) m_valid = 0;
    m_irq = en && m_ovf;
    exp_q.push_back({m_irq, m_valid, m_syn, rec()});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input logic en, input string tag);
    step(0, 0, '0, '0, 0, 0, '0, en, tag);
  endtask

  // monitor
  always @(posedge clk_i) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [73:0] e, a;
      string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      a = {fault_irq_o, rec_valid_o, rec_syn_o, misc_rdata_o};
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: actual irq=%0b valid=%0b syn=%h rd=%h expected irq=%0b valid=%0b syn=%h rd=%h",
                 t, a[73], a[72], a[71:64], a[63:0], e[73], e[72], e[71:64], e[63:0]);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1;
    checks++;
    if ({fault_irq_o, rec_valid_o, rec_syn_o, misc_rdata_o} !== 74'd0) begin
      fails++;
      $display("FAIL R1: actual rd=%h valid=%0b expected all zero", misc_rdata_o, rec_valid_o);
    end
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    idle(0, "R1 idle after reset");
    step(1, 1, 8'h05, 32'hFFFF_FFFF, 0, 0, '0, 0, "R2 R9 first load masks info");
    step(1, 1, 8'h05, 32'h1111_1111, 0, 0, '0, 0, "R4 matching syndrome");
    step(1, 0, 8'h09, 32'h2222_2222, 0, 0, '0, 0, "R4 uncorrected");
    step(1, 1, 8'h09, 32'h3333_3333, 0, 0, '0, 0, "R3 increment to 1");
    step(1, 1, 8'h0A, 32'h0, 0, 0, '0, 0, "R3 increment to 2");
    step(0, 0, '0, '0, 1, 0, 64'hFFFF_FFFE_0000_1234, 0, "R7 R8 R9 count write, info locked");
    step(1, 1, 8'h03, 32'h0, 0, 0, '0, 1, "R3 count FF");
    step(1, 1, 8'h03, 32'h0, 0, 0, '0, 1, "R5 R6 wrap sets overflow and irq");
    step(1, 1, 8'h04, 32'h0, 0, 0, '0, 1, "R5 overflow sticky");
    idle(0, "R6 irq drops with enable");
    idle(1, "R6 irq returns with enable");
    step(0, 0, '0, '0, 1, 0, 64'h0000_0210_0000_0000, 1, "R7 clear overflow keep count write");
    step(1, 1, 8'h07, 32'h0, 1, 0, 64'h0000_0020_0000_0000, 0, "R10 collision sets rounding bit");
    step(0, 0, '0, '0, 1, 0, 64'h0000_0320_0000_0000, 0, "R7 rounding bit kept on write 1");
    step(0, 0, '0, '0, 1, 0, 64'h0000_0120_0000_0000, 0, "R7 rounding bit cleared on write 0");
    step(0, 0, '0, '0, 1, 1, 64'hFFFF_FFFF_FFFF_FFFE, 0, "R11 status write bit0=0 no effect");
    step(0, 0, '0, '0, 1, 1, 64'h1, 0, "R11 status clear");
    step(0, 0, '0, '0, 1, 0, 64'h0000_0020_ABCD_0123, 0, "R8 R9 info write accepted when empty");
    step(1, 0, 8'h44, 32'h0000_5678, 0, 0, '0, 0, "R2 reload after clear, count kept");
    step(1, 1, 8'h44, 32'h0, 0, 0, '0, 0, "R4 matching syndrome after reload");
    idle(0, "R1 final idle");
    @(negedge clk_i); err_valid_i = 0; reg_wr_i = 0;
    repeat (3) @(negedge clk_i);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule